// File: doc/BRIEF.md
# Prioritised Masked Interrupt Collector

This block gathers event pulses from six interrupt sources: a fast periodic timer, a slow periodic timer, two USB endpoint handshake reports, a GPIO aggregator and a wake-up pin. Each source sets its own pending latch. One 8-bit enable register, written by the core, decides which pending sources may interrupt. The block presents one request line and a 3-bit vector for the highest-priority source that is both pending and enabled.

The core acknowledges the vector that is being presented. That acknowledge clears the matching pending latch. Acknowledging the GPIO vector also clears the GPIO enable bit, so the handler must set that bit again before GPIO can interrupt a second time. The endpoint 0 event is qualified by its handshake: a host write that was NAKed produces no event. The wake-up source is edge-triggered, and it is held in its latch until it is acknowledged.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset the enable register reads 0, no source is pending, `irq` is 0 and `vec` is 0.
- R2: A write stores all eight bits of `en_wdata`, and `en_rdata` returns them from the next cycle. Bits 0 and 5 have no effect on any interrupt.
- R3: The enable bit for each source is fixed: fast timer bit 1, slow timer bit 2, endpoint 0 bit 3, endpoint 1 bit 4, GPIO bit 6 and wake bit 7. `irq` is 1 exactly when at least one pending source has its enable bit set.
- R4: When `irq` is 1, `vec` gives the lowest-numbered source that is pending and enabled. The codes are: fast timer 0, slow timer 1, endpoint 0 2, endpoint 1 3, GPIO 4, wake 5.
- R5: An `ack` in a cycle where `irq` is 1 clears the pending latch of the presented vector, and only that latch. If that source has an event in the same cycle, its latch stays set.
- R6: A source whose enable bit is 0 stays pending. It raises `irq` as soon as its bit is written to 1.
- R7: Acknowledging vector 4 clears enable bit 6. If a register write happens in the same cycle, the written value wins.
- R8: The wake source becomes pending on a rising edge of `wake_pin`. A pin that stays high does not make it pending again after it is acknowledged.
- R9: Endpoint 0 becomes pending on `ep0_in_acked`, or on `ep0_out_done` when `ep0_out_nak` is 0. Endpoint 1 becomes pending only on `ep1_in_acked`.
- R10: An `ack` while `irq` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_fast_tick | input | 1 | Fast timer event pulse |
| tmr_slow_tick | input | 1 | Slow timer event pulse |
| ep0_out_done | input | 1 | Host data reception on endpoint 0 finished |
| ep0_out_nak | input | 1 | That reception was NAKed; qualifies `ep0_out_done` |
| ep0_in_acked | input | 1 | Endpoint 0 transmission was ACKed by the host |
| ep1_in_acked | input | 1 | Endpoint 1 transmission was ACKed by the host |
| gpio_evt | input | 1 | GPIO aggregator event pulse |
| wake_pin | input | 1 | Wake-up pin level |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents |
| ack | input | 1 | Core acknowledges the presented vector |
| irq | output | 1 | Interrupt request to the core |
| vec | output | 3 | Index of the presented source |

## Verification
Two things can land in the same cycle. In the first, an acknowledge meets a new event from the source being acknowledged: a fast-timer tick is driven together with `ack`, and the vector must remain presented afterwards. In the second, a GPIO acknowledge meets a register write: `ack` on vector 4 is driven with an `en_we` that sets bit 6, and the read-back value must match the written data rather than the cleared bit. A sweep over every pending pattern and every combination of the six active enable bits drains each case by acknowledging one vector at a time. Each vector is compared with a priority model held in the bench.

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
  parameter int NSRC = 6,
  parameter int VW   = 3,
  parameter int RW   = 8,
  parameter int GPIO_SRC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_fast_tick,
  input  logic          tmr_slow_tick,
  input  logic          ep0_out_done,
  input  logic          ep0_out_nak,
  input  logic          ep0_in_acked,
  input  logic          ep1_in_acked,
  input  logic          gpio_evt,
  input  logic          wake_pin,
  input  logic          en_we,
  input  logic [RW-1:0] en_wdata,
  output logic [RW-1:0] en_rdata,
  input  logic          ack,
  output logic          irq,
  output logic [VW-1:0] vec
);
  localparam int GPIO_BIT = 6;

  logic [RW-1:0]   en_q;
  logic [NSRC-1:0] pend_q;
  logic            wake_d;
  logic [NSRC-1:0] ev, gate, act, ack_hit;

  assign ev = {wake_pin & ~wake_d, gpio_evt, ep1_in_acked,
               ep0_in_acked | (ep0_out_done & ~ep0_out_nak),
               tmr_slow_tick, tmr_fast_tick};
  assign gate = {en_q[7], en_q[6], en_q[4:1]};
  assign act  = pend_q & gate;
  assign irq  = |act;
  assign en_rdata = en_q;

  always_comb begin
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) vec = VW'(i);
  end

  assign ack_hit = (ack && irq) ? (NSRC'(1) << vec) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      wake_d <= 1'b0;
    end else begin
      wake_d <= wake_pin;
      pend_q <= (pend_q & ~ack_hit) | ev;
      if (en_we) en_q <= en_wdata;
      else if (ack_hit[GPIO_SRC]) en_q[GPIO_BIT] <= 1'b0;
    end
  end
endmodule

module irq_prio_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_fast_tick,
  input logic       tmr_slow_tick,
  input logic       ep0_out_done,
  input logic       ep0_in_acked,
  input logic       ep1_in_acked,
  input logic       gpio_evt,
  input logic       wake_pin,
  input logic       en_we,
  input logic [7:0] en_wdata,
  input logic [7:0] en_rdata,
  input logic       ack,
  input logic       irq,
  input logic [2:0] vec
);
  logic no_ev;
  assign no_ev = !(tmr_fast_tick || tmr_slow_tick || ep0_out_done || ep0_in_acked ||
                   ep1_in_acked || gpio_evt || wake_pin);

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_rdata == $past(en_wdata));
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_rdata & 8'hDE) == 8'h00) |-> !irq);
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> vec <= 3'd5);
  a_r7_gpio_bit_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack && vec == 3'd4 && !en_we) |=> !en_rdata[6]);
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && no_ev && !en_we) |=> (!irq && $stable(en_rdata)));
endmodule

bind irq_prio_ctl irq_prio_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_fast_tick(tmr_fast_tick), .tmr_slow_tick(tmr_slow_tick),
  .ep0_out_done(ep0_out_done), .ep0_in_acked(ep0_in_acked), .ep1_in_acked(ep1_in_acked),
  .gpio_evt(gpio_evt), .wake_pin(wake_pin), .en_we(en_we), .en_wdata(en_wdata),
  .en_rdata(en_rdata), .ack(ack), .irq(irq), .vec(vec));

// File: tb/test_irq_prio_ctl.sv
module test_irq_prio_ctl;
  logic clk = 0, rst_n = 0;
  logic tf = 0, ts = 0, e0o = 0, e0n = 0, e0i = 0, e1i = 0, ge = 0, wk = 0;
  logic we = 0, ack = 0;
  logic [7:0] wd = 0, rd;
  logic irq;
  logic [2:0] vec;
  int n_chk = 0, n_bad = 0;
  logic [5:0] m_pend;
  logic [7:0] m_en;

  always #2.5 clk = ~clk;

  irq_prio_ctl i_irq_prio_ctl (
    .clk(clk), .rst_n(rst_n), .tmr_fast_tick(tf), .tmr_slow_tick(ts),
    .ep0_out_done(e0o), .ep0_out_nak(e0n), .ep0_in_acked(e0i), .ep1_in_acked(e1i),
    .gpio_evt(ge), .wake_pin(wk), .en_we(we), .en_wdata(wd), .en_rdata(rd),
    .ack(ack), .irq(irq), .vec(vec));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] gatem(input logic [7:0] e);
    return {e[7], e[6], e[4:1]};
  endfunction

  function automatic logic [2:0] pick(input logic [5:0] a);
    for (int i = 0; i < 6; i++) if (a[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic fire(input logic [5:0] m);
    @(negedge clk);
    tf = m[0]; ts = m[1]; e0i = m[2]; e1i = m[3]; ge = m[4]; wk = m[5];
    @(negedge clk);
    tf = 0; ts = 0; e0i = 0; e1i = 0; ge = 0; wk = 0;
    m_pend |= m;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1; wd = v;
    @(negedge clk); we = 0;
    m_en = v;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 7; k++) begin
      logic [5:0] a;
      a = m_pend & gatem(m_en);
      chk(req, {31'd0, irq}, {31'd0, |a});
      if (a == 0) break;
      chk("R4", {29'd0, vec}, {29'd0, pick(a)});
      ack = 1;
      @(negedge clk); ack = 0;
      m_pend[pick(a)] = 0;
      if (pick(a) == 3'd4) m_en[6] = 0;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_pend = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdata", {24'd0, rd}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 vec", {29'd0, vec}, 0);

    // R2: bits 0 and 5 stored, but they have no effect
    fire(6'h3F);
    wr(8'h21);
    chk("R2 readback", {24'd0, rd}, 32'h21);
    chk("R2 no effect", {31'd0, irq}, 0);
    // R6: pending survives the mask
    wr(8'h80);
    chk("R6 raise", {31'd0, irq}, 1);
    chk("R6 vec", {29'd0, vec}, 5);
    wr(8'hFF);
    drain("R3");

    // R3/R4 sweep over all pending and enable combinations
    for (int e = 0; e < 64; e++) begin
      for (int p = 1; p < 64; p++) begin
        logic [7:0] ev;
        ev = {e[5], e[4], 1'b0, e[3], e[2], e[1], e[0], 1'b0};
        fire(6'(p));
        wr(ev);
        drain("R3");
        wr(8'hFF);
        drain("R6");
      end
    end

    // R5: an acknowledge that meets a new event from the same source keeps it pending
    wr(8'h02);
    fire(6'h01);
    @(negedge clk); ack = 1; tf = 1;
    @(negedge clk); ack = 0; tf = 0;
    chk("R5 same-cycle event", {31'd0, irq}, 1);
    drain("R5");
    // R5: only the presented latch is cleared
    wr(8'h06);
    fire(6'h03);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    m_pend[0] = 0;
    chk("R5 other stays", {29'd0, vec}, 1);
    drain("R5");

    // R7: a write in the same cycle beats the GPIO enable clear
    wr(8'h40);
    fire(6'h10);
    @(negedge clk); ack = 1; we = 1; wd = 8'h42;
    @(negedge clk); ack = 0; we = 0;
    chk("R7 write wins", {24'd0, rd}, 32'h42);
    // R7: a GPIO acknowledge alone clears bit 6
    fire(6'h10);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R7 clear", {24'd0, rd}, 32'h02);
    m_pend = 0; m_en = 8'h02;

    // R8: a pin held high does not pend again
    wr(8'h80);
    @(negedge clk); wk = 1;
    @(negedge clk);
    chk("R8 edge", {29'd0, irq, vec}, {29'd0, 1'b1, 3'd5});
    ack = 1;
    @(negedge clk); ack = 0;
    repeat (3) @(negedge clk);
    chk("R8 held", {31'd0, irq}, 0);
    wk = 0;
    @(negedge clk);

    // R9: endpoint handshake qualification
    wr(8'hFF);
    @(negedge clk); e0o = 1; e0n = 1;
    @(negedge clk); e0o = 0; e0n = 0;
    chk("R9 nak", {31'd0, irq}, 0);
    @(negedge clk); e0o = 1;
    @(negedge clk); e0o = 0;
    chk("R9 ep0 out", {29'd0, irq, vec}, {29'd0, 1'b1, 3'd2});
    ack = 1; @(negedge clk); ack = 0;
    @(negedge clk); e1i = 1;
    @(negedge clk); e1i = 0;
    chk("R9 ep1", {29'd0, irq, vec}, {29'd0, 1'b1, 3'd3});
    ack = 1; @(negedge clk); ack = 0;

    // R10: an acknowledge with no request changes nothing
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R10 en", {24'd0, rd}, 32'hFF);
    chk("R10 irq", {31'd0, irq}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule